// File: doc/BRIEF.md
# Matrix Keypad Scan Controller

This controller reads a switch matrix of up to five rows by five columns and turns key activity into a stream of press and release events. Row inputs idle high through external pull-ups. Each column output either pulls its line low or leaves it released. While nothing is pressed, the controller holds every enabled column low and watches the enabled rows. When any enabled row drops low, it starts scanning. In each scan it pulls the columns low one after another and records which rows follow.

A key counts as pressed only when two consecutive scans both see it pressed, and as released only when two consecutive scans both see it released. Between scans the controller waits for a selectable interval counted in ticks of a slow timer. It goes back to idle once no key is held and the last scan saw nothing. A row that reads low under every enabled column is reported as that row's grounded extension key rather than as every key on the row. Every event carries a seven-bit identifier and a one-bit state. Rows and columns can be enabled one by one, so smaller matrices leave the other pins untouched.

Top module: `keypad_scanner`

## Requirements
- R1: While idle, `col_drive_low` equals `col_en` and `ev_valid` is 0, including during reset. An enabled row reading low at a clock edge in idle makes the next cycle the first scan cycle.
- R2: A scan takes one cycle per column index, from 0 to NCOLS-1. In the cycle for column c, only bit c of `col_drive_low` may be 1, and it is 1 only if `col_en[c]` is 1. The rows are sampled at the end of that cycle. One cycle with all columns released follows the last column.
- R3: Between two scans, all columns are released for exactly (`wait_sel`+1) x WAIT_STEP_TICKS x TICK_CYCLES cycles. `wait_sel` values 0 to 3 give 10, 20, 30 and 40 ms with the default parameters at a 100 MHz clock. `wait_sel` is captured when the wait begins.
- R4: A key becomes held only after two consecutive scans both see it pressed. It is released only after two consecutive scans both see it released. A press seen in a single scan produces no event.
- R5: Every key that changes in one scan is reported, one event per clock, in ascending identifier order. The events start in the cycle after the release cycle of R2.
- R6: The identifier of the key at row r and column c is r x NCOLS + c + 1, which gives 1 to 25 for a 5 x 5 matrix. An event drives `ev_state` to 1 for a press and to 0 for a release, with `ev_valid` high for exactly one cycle.
- R7: An enabled row that reads low under every enabled column, with at least one column enabled, is reported as the grounded key GND_BASE + r (31 + r by default). No individual key on that row is reported while this lasts.
- R8: A row with `row_en` at 0 and a column with `col_en` at 0 are never driven, never start a scan and never produce an event.
- R9: After the event cycles of a scan, the controller returns to idle if no key is held and that scan saw no key. Otherwise it enters the wait of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_en | input | NROWS | Row pin enables |
| col_en | input | NCOLS | Column pin enables |
| wait_sel | input | 2 | Wait interval selection between scans |
| row_in | input | NROWS | Row levels, low when connected to a low column or grounded |
| col_drive_low | output | NCOLS | 1 pulls the column low, 0 releases it |
| ev_valid | output | 1 | An event is present this cycle |
| ev_id | output | 7 | Key identifier of the event |
| ev_state | output | 1 | 1 for press, 0 for release |

## Verification
The hardest cases to reach from the ports depend on when a key changes relative to the scan. One is a press that lasts for exactly one scan. Another is a grounded row that also has an ordinary key pressed on it. A third is several keys changing within the same scan. The bench models the matrix as a combinational function of the column outputs. It changes key positions at chosen points after a clock edge, so that a press can cover only the first column sample of a scan, and several keys can change together. A behavioural model follows every clock. It predicts the column outputs and the events, and it checks each wait length under a different `wait_sel` setting.

// File: rtl/kps_pkg.sv
package kps_pkg;

   localparam int EV_ID_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_EVAL,
      ST_EMIT,
      ST_WAIT
   } scan_state_e;

endpackage

// File: rtl/kps_sampler.sv
module kps_sampler #(
   parameter  int NROWS = 5,
   parameter  int NCOLS = 5,
   localparam int NKEY  = NROWS * NCOLS,
   localparam int NSLOT = NKEY + NROWS,
   localparam int CI_W  = $clog2(NCOLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [CI_W-1:0]  col_sel,
   input  logic [NROWS-1:0] row_en,
   input  logic [NCOLS-1:0] col_en,
   input  logic [NROWS-1:0] row_in,
   output logic [NSLOT-1:0] raw_slots
);

   for (genvar r = 0; r < NROWS; r++) begin : g_row
      logic [NCOLS-1:0] samp_q;
      logic             grounded;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            samp_q <= '0;
         end else if (capture) begin
            for (int c = 0; c < NCOLS; c++) begin
               if (col_sel == CI_W'(c)) begin
                  samp_q[c] <= row_en[r] & col_en[c] & ~row_in[r];
               end
            end
         end
      end

      // a row low under every enabled column is its grounded extension key
      assign grounded = row_en[r] & (|col_en) & (&(samp_q | ~col_en));

      assign raw_slots[NKEY + r]           = grounded;
      assign raw_slots[r*NCOLS +: NCOLS]   = grounded ? '0 : samp_q;
   end

endmodule

// File: rtl/kps_debounce.sv
module kps_debounce #(
   parameter int NSLOT = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             update,
   input  logic [NSLOT-1:0] raw,
   output logic [NSLOT-1:0] held_q,
   output logic [NSLOT-1:0] held_next,
   output logic             busy
);

   logic [NSLOT-1:0] prev_q;

   // set on two pressed scans, clear on two released scans, else keep
   always_comb begin
      held_next = (raw & prev_q) | (held_q & (raw | prev_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         prev_q <= '0;
      end else if (update) begin
         held_q <= held_next;
         prev_q <= raw;
      end
   end

   assign busy = (|held_q) | (|prev_q);

   for (genvar k = 0; k < NSLOT; k++) begin : g_chk
      p_press_two_scans_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(held_q[k]) |-> (prev_q[k] && $past(prev_q[k])));
      p_release_two_scans_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         $fell(held_q[k]) |-> (!prev_q[k] && !$past(prev_q[k])));
   end

endmodule

// File: rtl/kps_emit.sv
module kps_emit
   import kps_pkg::*;
#(
   parameter  int NKEY     = 25,
   parameter  int NGND     = 5,
   parameter  int GND_BASE = 31,
   localparam int NSLOT    = NKEY + NGND
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               advance,
   input  logic [NSLOT-1:0]   chg,
   input  logic [NSLOT-1:0]   held,
   output logic               ev_valid,
   output logic [EV_ID_W-1:0] ev_id,
   output logic               ev_state,
   output logic               empty
);

   logic [NSLOT-1:0]   pend_q;
   logic [NSLOT-1:0]   low_bit;
   logic [EV_ID_W-1:0] id_terms [NSLOT];

   // isolate the lowest pending slot: lowest slot is lowest identifier
   assign low_bit  = pend_q & (~pend_q + NSLOT'(1));
   assign empty    = ~|pend_q;
   assign ev_valid = advance & ~empty;
   assign ev_state = |(low_bit & held);

   for (genvar k = 0; k < NSLOT; k++) begin : g_id
      localparam int SLOT_ID = (k < NKEY) ? (k + 1) : (GND_BASE + k - NKEY);
      assign id_terms[k] = low_bit[k] ? EV_ID_W'(SLOT_ID) : '0;
   end

   always_comb begin
      ev_id = '0;
      for (int k = 0; k < NSLOT; k++) begin
         ev_id = ev_id | id_terms[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (load) begin
         pend_q <= chg;
      end else if (ev_valid) begin
         pend_q <= pend_q & ~low_bit;
      end
   end

   p_ascending_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && $past(ev_valid)) |-> (ev_id > $past(ev_id)));

   p_id_range_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> ((int'(ev_id) >= 1 && int'(ev_id) <= NKEY) ||
                    (int'(ev_id) >= GND_BASE && int'(ev_id) < GND_BASE + NGND)));

endmodule

// File: rtl/kps_wait_timer.sv
module kps_wait_timer #(
   parameter  int TICK_CYCLES     = 100000,
   parameter  int WAIT_STEP_TICKS = 10,
   parameter  int SEL_W           = 2,
   localparam int PRE_W           = $clog2(TICK_CYCLES),
   localparam int MAX_TICKS       = (2 ** SEL_W) * WAIT_STEP_TICKS,
   localparam int TK_W            = $clog2(MAX_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             done
);

   if (TICK_CYCLES < 2 || WAIT_STEP_TICKS < 1) begin : g_bad_cfg
      $error("kps_wait_timer: TICK_CYCLES must be >= 2 and WAIT_STEP_TICKS >= 1");
   end

   logic [PRE_W-1:0] pre_q;
   logic [TK_W-1:0]  tk_q;
   logic [SEL_W-1:0] sel_q;
   logic [TK_W-1:0]  limit;
   logic             pre_last;

   assign limit    = TK_W'((int'(sel_q) + 1) * WAIT_STEP_TICKS);
   assign pre_last = (pre_q == PRE_W'(TICK_CYCLES - 1));
   assign done     = run & pre_last & (tk_q == limit - TK_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         tk_q  <= '0;
         sel_q <= '0;
      end else if (start) begin
         pre_q <= '0;
         tk_q  <= '0;
         sel_q <= sel;
      end else if (run) begin
         if (pre_last) begin
            pre_q <= '0;
            tk_q  <= tk_q + TK_W'(1);
         end else begin
            pre_q <= pre_q + PRE_W'(1);
         end
      end
   end

   p_wait_limit_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (tk_q < limit));

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
   import kps_pkg::*;
#(
   parameter  int NROWS           = 5,
   parameter  int NCOLS           = 5,
   parameter  int GND_BASE        = 31,
   parameter  int TICK_CYCLES     = 100000,
   parameter  int WAIT_STEP_TICKS = 10,
   localparam int NKEY            = NROWS * NCOLS,
   localparam int NSLOT           = NKEY + NROWS,
   localparam int CI_W            = $clog2(NCOLS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NROWS-1:0]   row_en,
   input  logic [NCOLS-1:0]   col_en,
   input  logic [1:0]         wait_sel,
   input  logic [NROWS-1:0]   row_in,
   output logic [NCOLS-1:0]   col_drive_low,
   output logic               ev_valid,
   output logic [EV_ID_W-1:0] ev_id,
   output logic               ev_state
);

   if (NROWS < 1 || NCOLS < 2 || NKEY >= GND_BASE || GND_BASE + NROWS > 128) begin : g_bad_cfg
      $error("keypad_scanner: matrix size does not fit the identifier space");
   end

   scan_state_e      state_q;
   logic [CI_W-1:0]  col_q;
   logic [NCOLS-1:0] col_onehot;
   logic [NSLOT-1:0] raw_slots;
   logic [NSLOT-1:0] held_q;
   logic [NSLOT-1:0] held_next;
   logic             busy;
   logic             emit_empty;
   logic             wait_done;
   logic             idle_hit;
   logic             col_last;
   logic             wait_start;

   assign idle_hit   = |(row_en & ~row_in);
   assign col_last   = (col_q == CI_W'(NCOLS - 1));
   assign wait_start = (state_q == ST_EMIT) & emit_empty & busy;

   for (genvar c = 0; c < NCOLS; c++) begin : g_col
      assign col_onehot[c] = (col_q == CI_W'(c));
   end

   always_comb begin
      case (state_q)
         ST_IDLE: col_drive_low = col_en;
         ST_SCAN: col_drive_low = col_en & col_onehot;
         default: col_drive_low = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         col_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (idle_hit) begin
                  state_q <= ST_SCAN;
                  col_q   <= '0;
               end
            end
            ST_SCAN: begin
               if (col_last) begin
                  state_q <= ST_EVAL;
               end else begin
                  col_q <= col_q + CI_W'(1);
               end
            end
            ST_EVAL: state_q <= ST_EMIT;
            ST_EMIT: begin
               if (emit_empty) begin
                  state_q <= busy ? ST_WAIT : ST_IDLE;
               end
            end
            ST_WAIT: begin
               if (wait_done) begin
                  state_q <= ST_SCAN;
                  col_q   <= '0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   kps_sampler #(
      .NROWS (NROWS),
      .NCOLS (NCOLS)
   ) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (state_q == ST_SCAN),
      .col_sel   (col_q),
      .row_en    (row_en),
      .col_en    (col_en),
      .row_in    (row_in),
      .raw_slots (raw_slots)
   );

   kps_debounce #(
      .NSLOT (NSLOT)
   ) u_debounce (
      .clk       (clk),
      .rst_n     (rst_n),
      .update    (state_q == ST_EVAL),
      .raw       (raw_slots),
      .held_q    (held_q),
      .held_next (held_next),
      .busy      (busy)
   );

   kps_emit #(
      .NKEY     (NKEY),
      .NGND     (NROWS),
      .GND_BASE (GND_BASE)
   ) u_emit (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_q == ST_EVAL),
      .advance  (state_q == ST_EMIT),
      .chg      (held_next ^ held_q),
      .held     (held_q),
      .ev_valid (ev_valid),
      .ev_id    (ev_id),
      .ev_state (ev_state),
      .empty    (emit_empty)
   );

   kps_wait_timer #(
      .TICK_CYCLES     (TICK_CYCLES),
      .WAIT_STEP_TICKS (WAIT_STEP_TICKS),
      .SEL_W           (2)
   ) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wait_start),
      .run   (state_q == ST_WAIT),
      .sel   (wait_sel),
      .done  (wait_done)
   );

   p_scan_start_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && idle_hit) |=> (state_q == ST_SCAN && col_q == '0));

   p_scan_one_col_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> ($countones(col_drive_low) <= 1));

   p_events_in_emit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> (state_q == ST_EMIT));

   p_disabled_col_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (col_drive_low & ~col_en) == '0);

   p_idle_clear_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && $past(state_q) == ST_EMIT) |-> (held_q == '0));

   for (genvar r = 0; r < NROWS; r++) begin : g_gnd_chk
      p_ground_excl_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         held_q[NKEY + r] |-> (held_q[r*NCOLS +: NCOLS] == '0));
   end

endmodule

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;

   localparam int NR   = 5;
   localparam int NC   = 5;
   localparam int TICK = 2;
   localparam int STEP = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] row_en;
   logic [4:0] col_en;
   logic [1:0] wait_sel;
   logic [4:0] row_in;
   logic [4:0] col_drive_low;
   logic       ev_valid;
   logic [6:0] ev_id;
   logic       ev_state;

   logic [4:0] keyr [NR];
   logic [4:0] gnd;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   keypad_scanner #(
      .NROWS           (NR),
      .NCOLS           (NC),
      .GND_BASE        (31),
      .TICK_CYCLES     (TICK),
      .WAIT_STEP_TICKS (STEP)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .row_en        (row_en),
      .col_en        (col_en),
      .wait_sel      (wait_sel),
      .row_in        (row_in),
      .col_drive_low (col_drive_low),
      .ev_valid      (ev_valid),
      .ev_id         (ev_id),
      .ev_state      (ev_state)
   );

   // key matrix: a row is low if grounded or if a pressed key meets a low column
   always_comb begin
      for (int r = 0; r < NR; r++) begin
         row_in[r] = !(gnd[r] || (|(keyr[r] & col_drive_low)));
      end
   end

   function automatic logic [4:0] rows_now(input logic [4:0] drv);
      logic [4:0] v;
      for (int r = 0; r < NR; r++) begin
         v[r] = !(gnd[r] || (|(keyr[r] & drv)));
      end
      return v;
   endfunction

   // ---------------- behavioural reference model ----------------
   bit         m_idle = 1'b1;
   logic [4:0] m_col  = '0;
   bit         m_ev   = 1'b0;
   int         m_id   = 0;
   bit         m_st   = 1'b0;
   bit         mheld [64];
   bit         mprev [64];
   bit         mraw  [64];
   logic [4:0] msamp [NR];
   int         chg_q [$];

   initial begin
      for (int i = 0; i < 64; i++) begin
         mheld[i] = 1'b0;
         mprev[i] = 1'b0;
      end
      @(posedge rst_n);
      forever begin
         m_idle = 1'b1;
         m_ev   = 1'b0;
         do @(posedge clk); while (!(|(row_en & ~rows_now(col_en))));
         m_idle = 1'b0;
         while (1) begin
            for (int c = 0; c < NC; c++) begin
               logic [4:0] lv;
               m_col = col_en & (5'b00001 << c);
               @(posedge clk);
               lv = rows_now(m_col);
               for (int r = 0; r < NR; r++) begin
                  msamp[r][c] = row_en[r] && col_en[c] && !lv[r];
               end
            end
            m_col = '0;
            @(posedge clk);
            for (int i = 0; i < 64; i++) mraw[i] = 1'b0;
            for (int r = 0; r < NR; r++) begin
               if (row_en[r] && (col_en != 0) && ((msamp[r] | ~col_en) == 5'b11111)) begin
                  mraw[31 + r] = 1'b1;
               end else begin
                  for (int c = 0; c < NC; c++) mraw[r*5 + c + 1] = msamp[r][c];
               end
            end
            chg_q.delete();
            for (int id = 1; id < 64; id++) begin
               bit nh;
               if (mraw[id] && mprev[id]) nh = 1'b1;
               else if (!mraw[id] && !mprev[id]) nh = 1'b0;
               else nh = mheld[id];
               if (nh != mheld[id]) chg_q.push_back(id);
               mheld[id] = nh;
               mprev[id] = mraw[id];
            end
            foreach (chg_q[i]) begin
               m_ev = 1'b1;
               m_id = chg_q[i];
               m_st = mheld[chg_q[i]];
               @(posedge clk);
            end
            m_ev = 1'b0;
            @(posedge clk);
            begin
               bit any;
               any = 1'b0;
               for (int i = 0; i < 64; i++) any = any | mheld[i] | mprev[i];
               if (!any) break;
            end
            repeat ((int'(wait_sel) + 1) * STEP * TICK) @(posedge clk);
         end
      end
   end

   // ---------------- per-cycle comparison and event log ----------------
   logic [7:0] evlog [$];

   always @(negedge clk) begin
      if (rst_n) begin
         logic [4:0] exp_col;
         exp_col = m_idle ? col_en : m_col;
         checks++;
         if (col_drive_low !== exp_col) begin
            fails++;
            $display("FAIL R1 R2 R3 R8 R9 col_drive_low actual %b expected %b at %0t",
                     col_drive_low, exp_col, $time);
         end
         checks++;
         if (ev_valid !== m_ev || (m_ev && (int'(ev_id) != m_id || ev_state !== m_st))) begin
            fails++;
            $display("FAIL R4 R5 R6 R7 event actual v=%b id=%0d st=%b expected v=%b id=%0d st=%b at %0t",
                     ev_valid, ev_id, ev_state, m_ev, m_id, m_st, $time);
         end
         if (ev_valid) evlog.push_back({ev_state, ev_id});
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic expect_log(input string req, input logic [7:0] want [$]);
      checks++;
      if (evlog.size() != want.size()) begin
         fails++;
         $display("FAIL %s event count actual %0d expected %0d", req, evlog.size(), want.size());
      end else begin
         foreach (want[i]) begin
            if (evlog[i] !== want[i]) begin
               fails++;
               $display("FAIL %s event %0d actual %h expected %h", req, i, evlog[i], want[i]);
               break;
            end
         end
      end
      evlog.delete();
   endtask

   task automatic expect_col(input string req, input logic [4:0] want);
      @(negedge clk);
      checks++;
      if (col_drive_low !== want) begin
         fails++;
         $display("FAIL %s col_drive_low actual %b expected %b", req, col_drive_low, want);
      end
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      finish_run();
   end

   initial begin
      logic [7:0] want [$];
      rst_n    = 1'b0;
      row_en   = 5'h1F;
      col_en   = 5'h1F;
      wait_sel = 2'd0;
      gnd      = '0;
      for (int r = 0; r < NR; r++) keyr[r] = '0;

      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (col_drive_low !== col_en || ev_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset actual col=%b v=%b expected col=%b v=0", col_drive_low, ev_valid, col_en);
      end
      @(posedge clk);
      #2 rst_n = 1'b1;
      step(5);

      // R2 R6: single key row 1 column 2 -> id 8, scan column order
      keyr[1][2] = 1'b1;
      expect_col("R1 idle before scan", 5'h1F);
      expect_col("R2 scan column 0", 5'b00001);
      expect_col("R2 scan column 1", 5'b00010);
      step(200);
      keyr[1][2] = 1'b0;
      step(300);
      want = {8'h88, 8'h08};
      expect_log("R6 key 8 press and release", want);
      expect_col("R9 back to idle", 5'h1F);

      // R4: press seen by a single scan only
      keyr[0][0] = 1'b1;
      step(2);
      keyr[0][0] = 1'b0;
      step(300);
      want = {};
      expect_log("R4 one-scan glitch ignored", want);

      // R5: three keys together, ascending order
      keyr[0][2] = 1'b1;
      keyr[3][1] = 1'b1;
      keyr[4][4] = 1'b1;
      step(200);
      keyr[0][2] = 1'b0;
      keyr[3][1] = 1'b0;
      keyr[4][4] = 1'b0;
      step(300);
      want = {8'h83, 8'h91, 8'h99, 8'h03, 8'h11, 8'h19};
      expect_log("R5 multi key ascending", want);

      // R5: staggered presses report in time order
      keyr[3][4] = 1'b1;
      step(120);
      keyr[0][1] = 1'b1;
      step(120);
      keyr[3][4] = 1'b0;
      keyr[0][1] = 1'b0;
      step(300);
      want = {8'h94, 8'h82, 8'h02, 8'h14};
      expect_log("R5 staggered keys", want);

      // R7: grounded row 2 with a key on the same row -> id 33 only
      gnd[2]     = 1'b1;
      keyr[2][1] = 1'b1;
      step(200);
      gnd[2]     = 1'b0;
      keyr[2][1] = 1'b0;
      step(300);
      want = {8'hA1, 8'h21};
      expect_log("R7 grounded row key", want);

      // R3: longest wait selection
      wait_sel   = 2'd3;
      keyr[4][0] = 1'b1;
      step(400);
      keyr[4][0] = 1'b0;
      step(500);
      want = {8'h95, 8'h15};
      expect_log("R3 wait select 3", want);
      wait_sel = 2'd1;
      keyr[2][3] = 1'b1;
      step(250);
      keyr[2][3] = 1'b0;
      step(300);
      want = {8'h8E, 8'h0E};
      expect_log("R3 wait select 1", want);
      wait_sel = 2'd0;

      // R8: disabled row never scans nor reports
      row_en     = 5'b01111;
      keyr[4][0] = 1'b1;
      step(100);
      expect_col("R8 disabled row no scan", 5'h1F);
      keyr[4][0] = 1'b0;
      step(50);
      want = {};
      expect_log("R8 disabled row silent", want);
      row_en = 5'h1F;
      step(5);

      // R8: disabled column not driven, its key unseen
      col_en     = 5'b01111;
      keyr[0][4] = 1'b1;
      step(50);
      expect_col("R8 disabled column idle drive", 5'b01111);
      keyr[0][0] = 1'b1;
      step(200);
      keyr[0][0] = 1'b0;
      keyr[0][4] = 1'b0;
      step(300);
      want = {8'h81, 8'h01};
      expect_log("R8 disabled column key ignored", want);
      col_en = 5'h1F;
      step(5);

      expect_col("R9 final idle", 5'h1F);
      checks++;
      if (ev_valid !== 1'b0) begin
         fails++;
         $display("FAIL R9 final ev_valid actual %b expected 0", ev_valid);
      end
      finish_run();
   end

endmodule